// File: doc/BRIEF.md
# Push-Button Wiper Position Controller

This block turns two active-low push buttons into a saturating tap position for a 16-step digital potentiometer. Each button line goes through a two-flop synchronizer. The block then measures how long the button has been held, counting whole ticks of a 1 ms strobe, and moves the position one tap at a time. A short tap gives a single step. Holding the button repeats the step, first slowly and then, after a longer hold, quickly.

Pressing both buttons together has two outcomes:
- **Shutdown.** If the two presses start close together and are held long enough, the block enters shutdown. The position output then reads zero, and the stored tap is kept so that waking up restores it.
- **Ignored.** Any other overlap of the two buttons is ignored until both are released.

Other inputs and outputs:
- An inhibit input from the store logic masks both buttons.
- A one-cycle activity pulse tells the store logic that something happened.
- An initial position can be loaded, but only while reset is asserted.

All durations are parameters counted in ticks. Every duration below is counted only from the moment the synchronized button state reaches the controller.

Top module: `pb_wiper_ctrl`

## Requirements
- R1: The stored position is POS_W bits wide and saturates. Stepping up from the maximum (15 by default) leaves it at the maximum, and stepping down from 0 leaves it at 0. It never wraps.
- R2: A single button held for fewer than DB_TICKS ticks causes no change. When the button's held-tick count reaches DB_TICKS, the position moves one step. The up button (`up_n` low) moves it toward the maximum, and the down button (`dn_n` low) moves it toward 0.
- R3: While the same single button stays held and its held-tick count is below FAST_AFTER, one further step occurs every SLOW_TICKS ticks after the previous step.
- R4: Once the held-tick count has reached FAST_AFTER, the step interval becomes FAST_TICKS ticks. Releasing the button returns the block to idle with no further steps.
- R5: If the second button goes low before the first button's held-tick count has reached DB_TICKS, the two buttons are counted together. If both then stay low for SD_TICKS ticks, the block enters shutdown: `sd_o` reads 1 and `pos_o` reads 0.
- R6: If the second button goes low after the first button has already stepped, no further position change occurs. Shutdown is not entered, and the block waits until both buttons are released.
- R7: If both buttons are released before SD_TICKS ticks have been counted together, the position does not change and shutdown is not entered.
- R8: In shutdown, either of the following exits shutdown and restores the stored position on `pos_o`:
  - exactly one button held for DB_TICKS ticks;
  - `wake_n` held low for DB_TICKS ticks while no button is pressed.

  A shorter hold does not exit. If the waking button stays held until its held-tick count reaches SLOW_TICKS, the position steps once and then auto-repeats as in R3 and R4.
- R9: While `inhibit` is 1, both buttons are treated as released, and the position does not change.
- R10: The following apply while `rst` is 1:
  - `pos_o` takes `load_pos` when `load_en` is 1, and the midpoint (8 by default) otherwise.
  - `sd_o` and `act_o` read 0.
  - `load_en` has no effect when `rst` is 0.
- R11: `act_o` pulses for one cycle in each of these cases:
  - a press starts from idle;
  - `pos_o` changes, including entry to and exit from shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle strobe, nominally every 1 ms |
| up_n | input | 1 | Up button, active low, asynchronous |
| dn_n | input | 1 | Down button, active low, asynchronous |
| wake_n | input | 1 | Store-enable line, active low, used only to leave shutdown |
| inhibit | input | 1 | Masks both buttons while 1 (synchronous) |
| load_en | input | 1 | Selects `load_pos` as the reset position |
| load_pos | input | POS_W | Initial position loaded during reset |
| pos_o | output | POS_W | Current tap position, 0 in shutdown |
| sd_o | output | 1 | Shutdown flag |
| act_o | output | 1 | One-cycle activity pulse |

## Verification
The assertions take the following for granted:
- `inhibit` is synchronous to `clk`.
- `tick` is never high on two consecutive cycles.
- Reset lasts long enough to fill the synchronizers.

The bench keeps within these conditions. It drives every input one time unit after a rising edge, pulses `tick` for one cycle with idle cycles around it, and holds reset for several cycles. Between button events it leaves a settling gap with no ticks, so the synchronizer delay never shifts a tick count. Random presses and hold lengths use only a single button, and the two-button orderings are covered by directed cases.

// File: rtl/pb_wiper_pkg.sv
package pb_wiper_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARM,
        S_REP,
        S_BOTH,
        S_LOCK,
        S_SDHOLD,
        S_SD,
        S_WAKE
    } pb_state_e;

    function automatic int unsigned pb_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pb_sync.sv
module pb_sync #(
    parameter int unsigned WIDTH   = 3,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q <= RST_VAL;
                s2_q <= RST_VAL;
            end else begin
                s1_q <= d[i];
                s2_q <= s1_q;
            end
        end
        assign q[i] = s2_q;
    end
endmodule

// File: rtl/pb_sat_step.sv
module pb_sat_step #(
    parameter int unsigned POS_W = 4
) (
    input  logic [POS_W-1:0] pos,
    output logic [POS_W-1:0] pos_up,
    output logic [POS_W-1:0] pos_dn
);
    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

    assign pos_up = (pos == POS_MAX) ? pos : pos + 1'b1;
    assign pos_dn = (pos == '0)      ? pos : pos - 1'b1;
endmodule

// File: rtl/pb_rate.sv
module pb_rate #(
    parameter int unsigned CW         = 12,
    parameter int unsigned RW         = 8,
    parameter int unsigned FAST_AFTER = 1000,
    parameter int unsigned SLOW_TICKS = 250,
    parameter int unsigned FAST_TICKS = 50
) (
    input  logic [CW-1:0] t_now,
    input  logic [RW-1:0] r_now,
    output logic          due
);
    localparam logic [CW-1:0] T_FA   = CW'(FAST_AFTER);
    localparam logic [RW-1:0] R_SLOW = RW'(SLOW_TICKS);
    localparam logic [RW-1:0] R_FAST = RW'(FAST_TICKS);

    logic [RW-1:0] period;
    assign period = (t_now >= T_FA) ? R_FAST : R_SLOW;
    assign due    = (r_now >= period);
endmodule

// File: rtl/pb_wiper_ctrl.sv
module pb_wiper_ctrl
    import pb_wiper_pkg::*;
#(
    parameter int unsigned POS_W      = 4,
    parameter int unsigned DB_TICKS   = 15,
    parameter int unsigned SLOW_TICKS = 250,
    parameter int unsigned FAST_AFTER = 1000,
    parameter int unsigned FAST_TICKS = 50,
    parameter int unsigned SD_TICKS   = 2000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             up_n,
    input  logic             dn_n,
    input  logic             wake_n,
    input  logic             inhibit,
    input  logic             load_en,
    input  logic [POS_W-1:0] load_pos,
    output logic [POS_W-1:0] pos_o,
    output logic             sd_o,
    output logic             act_o
);
    localparam int unsigned T_MAX = pb_max(pb_max(SD_TICKS, FAST_AFTER), pb_max(SLOW_TICKS, DB_TICKS));
    localparam int unsigned CW    = $clog2(T_MAX + 2);
    localparam int unsigned RW    = $clog2(pb_max(SLOW_TICKS, FAST_TICKS) + 2);
    localparam logic [CW-1:0] T_DB   = CW'(DB_TICKS);
    localparam logic [CW-1:0] T_SLOW = CW'(SLOW_TICKS);
    localparam logic [CW-1:0] T_SD   = CW'(SD_TICKS);
    localparam logic [CW-1:0] T_SAT  = {CW{1'b1}};
    localparam logic [RW-1:0] R_SAT  = {RW{1'b1}};
    localparam logic [POS_W-1:0] POS_MID = {1'b1, {(POS_W-1){1'b0}}};

    typedef struct packed {
        pb_state_e        st;
        logic [POS_W-1:0] pos;
        logic [CW-1:0]    t;
        logic [RW-1:0]    r;
        logic             dir_up;
        logic             act;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // input synchronizers: bit0 up, bit1 down, bit2 wake
    logic [2:0] raw_s;
    pb_sync #(.WIDTH(3), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({wake_n, dn_n, up_n}),
        .q   (raw_s)
    );

    logic up_p, dn_p, wake_p, both_p, none_p, one_p;
    assign up_p   = ~raw_s[0] & ~inhibit;
    assign dn_p   = ~raw_s[1] & ~inhibit;
    assign wake_p = ~raw_s[2];
    assign both_p = up_p & dn_p;
    assign none_p = ~up_p & ~dn_p;
    assign one_p  = up_p ^ dn_p;

    logic [POS_W-1:0] pos_up, pos_dn, pos_step;
    pb_sat_step #(.POS_W(POS_W)) u_step (
        .pos    (ctl_q.pos),
        .pos_up (pos_up),
        .pos_dn (pos_dn)
    );
    assign pos_step = ctl_q.dir_up ? pos_up : pos_dn;

    logic [CW-1:0] t_inc;
    logic [RW-1:0] r_inc;
    logic          rep_due;
    logic [CW-1:0] first_t;
    assign t_inc   = (ctl_q.t == T_SAT) ? ctl_q.t : ctl_q.t + 1'b1;
    assign r_inc   = (ctl_q.r == R_SAT) ? ctl_q.r : ctl_q.r + 1'b1;
    assign first_t = (ctl_q.st == S_WAKE) ? T_SLOW : T_DB;

    pb_rate #(
        .CW         (CW),
        .RW         (RW),
        .FAST_AFTER (FAST_AFTER),
        .SLOW_TICKS (SLOW_TICKS),
        .FAST_TICKS (FAST_TICKS)
    ) u_rate (
        .t_now (t_inc),
        .r_now (r_inc),
        .due   (rep_due)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.act = 1'b0;
        unique case (ctl_q.st)
            S_IDLE: begin
                if (!none_p) begin
                    ctl_d.act    = 1'b1;
                    ctl_d.t      = '0;
                    ctl_d.r      = '0;
                    ctl_d.dir_up = up_p;
                    ctl_d.st     = both_p ? S_BOTH : S_ARM;
                end
            end
            S_ARM, S_WAKE: begin
                if (both_p) begin
                    ctl_d.st = (ctl_q.st == S_ARM) ? S_BOTH : S_LOCK;
                    ctl_d.t  = '0;
                end else if (none_p) begin
                    ctl_d.st = S_IDLE;
                end else if (up_p != ctl_q.dir_up) begin
                    ctl_d.st = S_LOCK;
                end else if (tick) begin
                    ctl_d.t = t_inc;
                    if (t_inc == first_t) begin
                        ctl_d.pos = pos_step;
                        ctl_d.act = (pos_step != ctl_q.pos);
                        ctl_d.r   = '0;
                        ctl_d.st  = S_REP;
                    end
                end
            end
            S_REP: begin
                if (both_p || (!none_p && (up_p != ctl_q.dir_up))) begin
                    ctl_d.st = S_LOCK;
                end else if (none_p) begin
                    ctl_d.st = S_IDLE;
                end else if (tick) begin
                    ctl_d.t = t_inc;
                    if (rep_due) begin
                        ctl_d.pos = pos_step;
                        ctl_d.act = (pos_step != ctl_q.pos);
                        ctl_d.r   = '0;
                    end else begin
                        ctl_d.r = r_inc;
                    end
                end
            end
            S_BOTH: begin
                if (!both_p) begin
                    ctl_d.st = S_LOCK;
                end else if (tick) begin
                    ctl_d.t = t_inc;
                    if (t_inc == T_SD) begin
                        ctl_d.st  = S_SDHOLD;
                        ctl_d.act = 1'b1;
                    end
                end
            end
            S_LOCK: begin
                if (none_p) ctl_d.st = S_IDLE;
            end
            S_SDHOLD: begin
                if (none_p) begin
                    ctl_d.st = S_SD;
                    ctl_d.t  = '0;
                end
            end
            S_SD: begin
                if (!(one_p || (wake_p && none_p))) begin
                    ctl_d.t = '0;
                end else if (tick) begin
                    ctl_d.t = t_inc;
                    if (t_inc == T_DB) begin
                        ctl_d.act = 1'b1;
                        if (one_p) begin
                            ctl_d.st     = S_WAKE;
                            ctl_d.dir_up = up_p;
                        end else begin
                            ctl_d.st = S_IDLE;
                        end
                    end
                end
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.st     <= S_IDLE;
            ctl_q.pos    <= load_en ? load_pos : POS_MID;
            ctl_q.t      <= '0;
            ctl_q.r      <= '0;
            ctl_q.dir_up <= 1'b0;
            ctl_q.act    <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sd_o  = (ctl_q.st == S_SD) || (ctl_q.st == S_SDHOLD);
    assign pos_o = sd_o ? '0 : ctl_q.pos;
    assign act_o = ctl_q.act;

    // R1: no wrap at either end
    p_no_wrap_top_r1: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.pos == {POS_W{1'b1}}) |=> (ctl_q.pos != '0));
    p_no_wrap_bot_r1: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.pos == '0) |=> (ctl_q.pos != {POS_W{1'b1}}));
    // R2: the stored position moves by one tap at most
    p_single_step_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctl_q.pos) |->
            (({1'b0, ctl_q.pos}) == ({1'b0, $past(ctl_q.pos)} + 1'b1)) ||
            (({1'b0, $past(ctl_q.pos)}) == ({1'b0, ctl_q.pos} + 1'b1)));
    // R5: shutdown is entered only while both buttons are held
    p_sd_entry_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(sd_o) |-> $past(both_p));
    // R8: the stored position is kept through shutdown
    p_sd_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        (sd_o && $past(sd_o)) |-> $stable(ctl_q.pos));
    // R9: inhibit freezes the position
    p_inhibit_r9: assert property (@(posedge clk) disable iff (rst)
        inhibit |=> $stable(ctl_q.pos));
    // R11: every output change comes with the activity pulse
    p_act_on_move_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(pos_o) |-> act_o);
endmodule

// File: tb/pb_wiper_ctrl_test.sv
module pb_wiper_ctrl_test;
    localparam int P_W    = 4;
    localparam int P_DB   = 3;
    localparam int P_SLOW = 8;
    localparam int P_FA   = 30;
    localparam int P_FAST = 2;
    localparam int P_SD   = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic up_n = 1'b1, dn_n = 1'b1, wake_n = 1'b1;
    logic inhibit = 1'b0, load_en = 1'b0;
    logic [P_W-1:0] load_pos = '0;
    logic [P_W-1:0] pos_o;
    logic sd_o, act_o;

    int checks = 0, fails = 0, act_cnt = 0, expv = 0;

    always #10 clk = ~clk;

    pb_wiper_ctrl #(
        .POS_W(P_W), .DB_TICKS(P_DB), .SLOW_TICKS(P_SLOW),
        .FAST_AFTER(P_FA), .FAST_TICKS(P_FAST), .SD_TICKS(P_SD)
    ) uut (
        .clk(clk), .rst(rst), .tick(tick), .up_n(up_n), .dn_n(dn_n),
        .wake_n(wake_n), .inhibit(inhibit), .load_en(load_en),
        .load_pos(load_pos), .pos_o(pos_o), .sd_o(sd_o), .act_o(act_o)
    );

    always @(negedge clk) if (!rst && act_o) act_cnt++;

    function automatic int mv(int p, bit up);
        if (up) return (p == 15) ? 15 : p + 1;
        return (p == 0) ? 0 : p - 1;
    endfunction

    function automatic int model(int start, bit up, int n, int first);
        int p = start, t = 0, r = 0;
        bit rep = 0;
        for (int i = 1; i <= n; i++) begin
            t++;
            if (!rep) begin
                if (t == first) begin p = mv(p, up); rep = 1; r = 0; end
            end else begin
                r++;
                if (r >= ((t >= P_FA) ? P_FAST : P_SLOW)) begin p = mv(p, up); r = 0; end
            end
        end
        return p;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 tick = 1'b1;
            @(posedge clk); #1 tick = 1'b0;
            idle(2);
        end
    endtask

    task automatic press(input bit u, input bit d, input int n);
        up_n = !u; dn_n = !d;
        idle(5);
        ticks(n);
        up_n = 1'b1; dn_n = 1'b1;
        idle(6);
    endtask

    task automatic samp_pos(input string req, input int exp);
        @(negedge clk);
        check(pos_o == exp[P_W-1:0], req, pos_o, exp);
        #1;
    endtask

    task automatic do_reset(input bit le, input int lv);
        rst = 1'b1; load_en = le; load_pos = lv[P_W-1:0];
        idle(4);
        rst = 1'b0;
        idle(1);
    endtask

    task automatic enter_sd();
        up_n = 1'b0; idle(5);
        ticks(1);
        dn_n = 1'b0; idle(5);
        ticks(P_SD + 2);
        up_n = 1'b1; dn_n = 1'b1;
        idle(6);
    endtask

    initial begin : main
        int b, n, a0;
        void'($urandom(32'd2024));
        // R10: reset to midpoint
        do_reset(1'b0, 0);
        @(negedge clk);
        check(pos_o == 8, "R10 midpoint", pos_o, 8);
        check(sd_o == 0 && act_o == 0, "R10 flags", {sd_o, act_o}, 0);
        #1;
        // R10: load during reset, ignored afterwards
        do_reset(1'b1, 3);
        load_pos = 4'd12; idle(5); load_en = 1'b0;
        expv = 3;
        samp_pos("R10 load", expv);
        // R2: short glitch ignored
        press(1, 0, P_DB - 1);
        samp_pos("R2 glitch", expv);
        // R2, R11: single step and activity pulses
        a0 = act_cnt;
        press(1, 0, P_DB);
        expv = 4;
        samp_pos("R2 single step", expv);
        check(act_cnt - a0 == 2, "R11 pulses", act_cnt - a0, 2);
        // R3: slow repeat
        press(1, 0, P_DB + 2 * P_SLOW);
        expv = model(4, 1, P_DB + 2 * P_SLOW, P_DB);
        samp_pos("R3 slow repeat", expv);
        check(expv == 7, "R3 model", expv, 7);
        // R4 and R1: fast repeat into top saturation
        press(1, 0, 50);
        expv = model(7, 1, 50, P_DB);
        samp_pos("R4 fast repeat", expv);
        check(pos_o == 15, "R1 top", pos_o, 15);
        // R1: bottom saturation
        press(0, 1, 120);
        expv = 0;
        samp_pos("R1 bottom", expv);
        press(1, 0, P_DB + P_SLOW);
        expv = 2;
        samp_pos("R3 two steps", expv);
        // R5: shutdown gesture
        enter_sd();
        @(negedge clk);
        check(sd_o == 1, "R5 sd flag", sd_o, 1);
        check(pos_o == 0, "R5 pos zero", pos_o, 0);
        #1;
        // R8: short press does not wake
        press(1, 0, P_DB - 1);
        @(negedge clk);
        check(sd_o == 1, "R8 short stays", sd_o, 1);
        #1;
        // R8: button wake restores
        press(1, 0, P_DB);
        @(negedge clk);
        check(sd_o == 0, "R8 wake flag", sd_o, 0);
        #1;
        samp_pos("R8 restore", 2);
        // R8: wake then auto-repeat
        enter_sd();
        press(0, 1, P_DB + P_SLOW + 4);
        expv = model(2, 0, P_DB + P_SLOW + 4, P_SLOW);
        samp_pos("R8 wake repeat", expv);
        check(expv == 1, "R8 model", expv, 1);
        // R8: wake input exits
        enter_sd();
        wake_n = 1'b0; idle(5); ticks(P_DB); wake_n = 1'b1; idle(6);
        @(negedge clk);
        check(sd_o == 0, "R8 wake input", sd_o, 0);
        #1;
        samp_pos("R8 wake input pos", expv);
        // R7: both pressed, released early
        press(1, 1, 10);
        samp_pos("R7 early release", expv);
        @(negedge clk);
        check(sd_o == 0, "R7 no sd", sd_o, 0);
        #1;
        // R6: late second press
        up_n = 1'b0; idle(5); ticks(P_DB + 2);
        dn_n = 1'b0; idle(5); ticks(P_SD + 5);
        up_n = 1'b1; dn_n = 1'b1; idle(6);
        expv = model(expv, 1, P_DB + 2, P_DB);
        samp_pos("R6 late overlap", expv);
        @(negedge clk);
        check(sd_o == 0, "R6 no sd", sd_o, 0);
        #1;
        // R9: inhibit masks buttons
        inhibit = 1'b1;
        press(1, 0, 20);
        samp_pos("R9 inhibit", expv);
        inhibit = 1'b0; idle(2);
        // random single-button presses: R2 R3 R4
        for (int k = 0; k < 24; k++) begin
            b = $urandom_range(0, 1);
            n = $urandom_range(0, 70);
            expv = model(expv, b[0], n, P_DB);
            press(b[0], !b[0], n);
            samp_pos("R4 random", expv);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule